// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Commit Tracking

This block generates two independent pulse-width modulated outputs. Each channel has four registers on a small synchronous register bus: control, clock divider, period and duty. Software writes a value, then polls one shared status word until the matching pending flag drops. Once the flag has dropped, the value has reached the logic that drives the counter. A fixed four-cycle commit delay stands in for the crossing into a slower counter clock.

Each written value passes through three copies. The bus-side copy is the one that reads back. The committed copy is filled when the pending flag clears. The working copy drives the divider, the counter and the comparator. An auto-reload control bit selects when the working copy picks up new values. When it is set, new period, duty and divider values take effect only at a period boundary, or at once while the channel is idle. When it is clear, the divider and period move only on an explicit load request, and a new duty value takes effect as soon as it commits. A disabled channel either finishes its current period or, if asked, goes quiet at once. An invert bit flips the polarity of the output, including its idle level.

Top module: `pwm_pair`

## Requirements
- R1: Channel n owns byte offsets 16n to 16n+15: control at +0, divider at +4, period at +8, duty at +12. Each register reads back its last written value, truncated to its width (divider 8 bits, period and duty 16 bits). Reads of any other offset, such as 0x20 or 0x44, return zero.
- R2: The status word at offset 0x40 holds channel n's flags in bits 8n+0 to 8n+3. Bit 0 is control, bit 1 is divider, bit 2 is period and bit 3 is duty. All other bits read zero.
- R3: A write sets its register's pending flag, which first reads as set one cycle after the write edge. The flag clears exactly four clock edges after the write. Writing the same register again while it is pending restarts the four-edge count.
- R4: A running channel repeats a frame of (period+1)·(divider+1) clocks. Its output is active for the first (duty+1)·(divider+1) clocks of each frame, and always active when duty ≥ period.
- R5: With control bit 2 (auto-reload) set, committed period, duty and divider values reach the working copy only at a period wrap, or continuously while the channel is idle.
- R6: With auto-reload clear, a committed duty value takes effect on the commit edge. The divider and period change only when a control write with bit 4 (load divider) or bit 5 (load period) set commits. These two bits always read back as 0.
- R7: Control bit 0 (enable) starts the channel from count zero. Writing 5 (enable plus auto-reload) starts a configured channel. Clearing enable without bit 3 lets the current period run to its wrap before the output goes idle.
- R8: Clearing enable with control bit 3 (stop now) set forces the output to its idle level on the first edge after the control commit.
- R9: Control bit 1 inverts the output in every state, so a disabled inverted channel drives 1.
- R10: After reset all registers and status flags read zero and both outputs are 0.
- R11: The two channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 7 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
The hardest cases to reach from the ports are the ones where a commit lands in the middle of a period. Auto-reload has to hold the old duty until the wrap, and a manual commit has to apply it at once. A stop without stop-now has to let the period finish, and a stop with stop-now has to cut it short. To reach these, the bench waits for the output's active edge, which marks count zero, then issues the write at that same sample point. It then counts clock edges from the write to a count position where the old and new behaviour give different output levels.

// File: rtl/pwmp_pkg.sv
package pwmp_pkg;
  localparam int unsigned REGS_PER_CH = 4;

  localparam int unsigned SEL_CTRL = 0;
  localparam int unsigned SEL_DIV  = 1;
  localparam int unsigned SEL_PER  = 2;
  localparam int unsigned SEL_DUTY = 3;

  localparam int unsigned LD_DIV_BIT = 4;
  localparam int unsigned LD_PER_BIT = 5;

  // Field order matches control bits 3..0.
  typedef struct packed {
    logic halt_now;
    logic auto_ld;
    logic invert;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/pwmp_rst_sync.sv
module pwmp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sr_q <= '0;
    else           sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_out = sr_q[1];
endmodule

// File: rtl/pwmp_sync_slot.sv
// Tracks one pending register commit with a fixed latency.
module pwmp_sync_slot #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign fire = busy && (cnt_q == '0) && !start;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end else if (fire) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwmp_chan.sv
module pwmp_chan
  import pwmp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16,
  parameter int LAT   = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [3:0]       pend,
  output logic             inv_o,
  output logic             halt_o,
  output logic             pwm_o
);
  logic [3:0] wr_hit, xfer;

  // bus-side copies
  ctrl_t            sh_ctrl_q, sh_ctrl_d;
  logic             ld_div_q, ld_div_d, ld_per_q, ld_per_d;
  logic [DIV_W-1:0] sh_div_q, sh_div_d;
  logic [CNT_W-1:0] sh_per_q, sh_per_d, sh_duty_q, sh_duty_d;
  // committed copies
  ctrl_t            syn_ctrl_q, syn_ctrl_d;
  logic [DIV_W-1:0] syn_div_q, syn_div_d;
  logic [CNT_W-1:0] syn_per_q, syn_per_d, syn_duty_q, syn_duty_d;
  // working copies
  logic [DIV_W-1:0] act_div_q, act_div_d;
  logic [CNT_W-1:0] act_per_q, act_per_d, act_duty_q, act_duty_d;
  // counter state
  logic             run_q, run_d;
  logic [DIV_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, wrap;

  genvar k;
  generate
    for (k = 0; k < REGS_PER_CH; k++) begin : g_slot
      assign wr_hit[k] = wr_en && (sel == 2'(k));
      pwmp_sync_slot #(.LAT(LAT)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_hit[k]),
        .busy  (pend[k]),
        .fire  (xfer[k])
      );
    end
  endgenerate

  assign tick = run_q && (pc_q >= act_div_q);
  assign wrap = tick && (cnt_q >= act_per_q);

  always_comb begin
    sh_ctrl_d  = sh_ctrl_q;
    ld_div_d   = ld_div_q;
    ld_per_d   = ld_per_q;
    sh_div_d   = sh_div_q;
    sh_per_d   = sh_per_q;
    sh_duty_d  = sh_duty_q;
    syn_ctrl_d = syn_ctrl_q;
    syn_div_d  = syn_div_q;
    syn_per_d  = syn_per_q;
    syn_duty_d = syn_duty_q;
    act_div_d  = act_div_q;
    act_per_d  = act_per_q;
    act_duty_d = act_duty_q;

    // bus writes
    if (wr_hit[SEL_CTRL]) begin
      sh_ctrl_d = ctrl_t'(wr_data[3:0]);
      ld_div_d  = wr_data[LD_DIV_BIT];
      ld_per_d  = wr_data[LD_PER_BIT];
    end else if (xfer[SEL_CTRL]) begin
      ld_div_d = 1'b0;
      ld_per_d = 1'b0;
    end
    if (wr_hit[SEL_DIV])  sh_div_d  = wr_data[DIV_W-1:0];
    if (wr_hit[SEL_PER])  sh_per_d  = wr_data;
    if (wr_hit[SEL_DUTY]) sh_duty_d = wr_data;

    // commits
    if (xfer[SEL_CTRL]) syn_ctrl_d = sh_ctrl_q;
    if (xfer[SEL_DIV])  syn_div_d  = sh_div_q;
    if (xfer[SEL_PER])  syn_per_d  = sh_per_q;
    if (xfer[SEL_DUTY]) syn_duty_d = sh_duty_q;

    // working copy
    if (syn_ctrl_q.auto_ld && (!run_q || wrap)) begin
      act_div_d  = syn_div_q;
      act_per_d  = syn_per_q;
      act_duty_d = syn_duty_q;
    end
    if (xfer[SEL_CTRL] && ld_div_q) act_div_d = syn_div_q;
    if (xfer[SEL_CTRL] && ld_per_q) act_per_d = syn_per_q;
    if (xfer[SEL_DUTY] && !syn_ctrl_q.auto_ld) act_duty_d = sh_duty_q;
  end

  always_comb begin
    run_d = run_q;
    pc_d  = pc_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      pc_d  = '0;
      cnt_d = '0;
      if (syn_ctrl_q.enable) run_d = 1'b1;
    end else if (!syn_ctrl_q.enable && syn_ctrl_q.halt_now) begin
      run_d = 1'b0;
      pc_d  = '0;
      cnt_d = '0;
    end else if (wrap) begin
      pc_d  = '0;
      cnt_d = '0;
      run_d = syn_ctrl_q.enable;
    end else if (tick) begin
      pc_d  = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctrl_q  <= '0;
      ld_div_q   <= 1'b0;
      ld_per_q   <= 1'b0;
      sh_div_q   <= '0;
      sh_per_q   <= '0;
      sh_duty_q  <= '0;
      syn_ctrl_q <= '0;
      syn_div_q  <= '0;
      syn_per_q  <= '0;
      syn_duty_q <= '0;
      act_div_q  <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      run_q      <= 1'b0;
      pc_q       <= '0;
      cnt_q      <= '0;
    end else begin
      sh_ctrl_q  <= sh_ctrl_d;
      ld_div_q   <= ld_div_d;
      ld_per_q   <= ld_per_d;
      sh_div_q   <= sh_div_d;
      sh_per_q   <= sh_per_d;
      sh_duty_q  <= sh_duty_d;
      syn_ctrl_q <= syn_ctrl_d;
      syn_div_q  <= syn_div_d;
      syn_per_q  <= syn_per_d;
      syn_duty_q <= syn_duty_d;
      act_div_q  <= act_div_d;
      act_per_q  <= act_per_d;
      act_duty_q <= act_duty_d;
      run_q      <= run_d;
      pc_q       <= pc_d;
      cnt_q      <= cnt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      2'd0:    rd_data[3:0]       = sh_ctrl_q;
      2'd1:    rd_data[DIV_W-1:0] = sh_div_q;
      2'd2:    rd_data[CNT_W-1:0] = sh_per_q;
      default: rd_data[CNT_W-1:0] = sh_duty_q;
    endcase
  end

  assign inv_o  = syn_ctrl_q.invert;
  assign halt_o = !syn_ctrl_q.enable && syn_ctrl_q.halt_now;
  assign pwm_o  = (run_q && (cnt_q <= act_duty_q)) ^ syn_ctrl_q.invert;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int NCH   = 2,
  parameter int DIV_W = 8,
  parameter int CNT_W = 16,
  parameter int LAT   = 4,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int STAT_OFF = 'h40;
  localparam int CHW      = AW - 4;

  logic             rst_sn;
  logic [CHW-1:0]   addr_ch;
  logic             aligned, is_stat;
  logic [NCH-1:0]   wr_en;
  logic [NCH-1:0]   ch_inv, ch_halt;
  logic [DW-1:0]    ch_rd   [NCH];
  logic [3:0]       ch_pend [NCH];
  logic [DW-1:0]    status_w;

  pwmp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  assign addr_ch = bus_addr[AW-1:4];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign is_stat = (bus_addr == AW'(STAT_OFF));

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      wr_en[n] = bus_we && aligned && (addr_ch == CHW'(n));
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      pwmp_chan #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W),
        .LAT   (LAT),
        .DW    (DW)
      ) u_chan (
        .clk     (clk),
        .rst_n   (rst_sn),
        .wr_en   (wr_en[c]),
        .sel     (bus_addr[3:2]),
        .wr_data (bus_wdata[CNT_W-1:0]),
        .rd_data (ch_rd[c]),
        .pend    (ch_pend[c]),
        .inv_o   (ch_inv[c]),
        .halt_o  (ch_halt[c]),
        .pwm_o   (pwm_out[c])
      );
    end
  endgenerate

  always_comb begin
    status_w = '0;
    for (int n = 0; n < NCH; n++) begin
      status_w[8*n +: 4] = ch_pend[n];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_stat) begin
      bus_rdata = status_w;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (aligned && (addr_ch == CHW'(n))) bus_rdata = ch_rd[n];
      end
    end
  end
endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker #(
  parameter int NCH = 2,
  parameter int AW  = 7,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [DW-1:0]  status_w,
  input logic [NCH-1:0] ch_inv,
  input logic [NCH-1:0] ch_halt
);
  // R3: a control write on channel 0 raises its pending flag next cycle
  p_wr_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> status_w[0]);

  // R3: a raised flag stays up for more than one cycle
  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w[1]) |=> status_w[1]);

  // R1: unmapped offset reads zero
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'('h44)) |-> (bus_rdata == '0));

  // R6: load request bits never read back
  p_ld_read0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0)) |-> (bus_rdata[5:4] == 2'b00));

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_stop
      // R8: committed stop-now idles the output on the next edge
      p_stop_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_halt[n] |=> (pwm_out[n] == ch_inv[n]));
    end
  endgenerate
endmodule

bind pwm_pair pwm_pair_checker #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .status_w  (status_w),
  .ch_inv    (ch_inv),
  .ch_halt   (ch_halt)
);

// File: tb/pwm_pair_test.sv
module pwm_pair_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  pwm_out;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  pwm_pair uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ra(input int ch, input int sel);
    return 7'(ch * 16 + sel * 4);
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input int ch, input int bitn);
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(7'h40, s);
      if (!s[8*ch+bitn]) break;
      @(negedge clk);
    end
    chk("R3 flag clears", 32'(s[8*ch+bitn]), 32'd0);
  endtask

  task automatic cfg(input int ch, input int sel, input logic [31:0] v);
    wr(ra(ch, sel), v);
    wait_idle(ch, sel);
  endtask

  function automatic logic act(input int ch, input logic inv);
    return pwm_out[ch] ^ inv;
  endfunction

  task automatic sync_rise(input int ch, input logic inv);
    for (int i = 0; i < 500 && act(ch, inv); i++) @(negedge clk);
    for (int i = 0; i < 500 && !act(ch, inv); i++) @(negedge clk);
  endtask

  task automatic meas(input int ch, input logic inv, output int hi, output int per);
    sync_rise(ch, inv);
    hi = 0;
    while (act(ch, inv) && hi < 2000) begin hi++; @(negedge clk); end
    per = hi;
    while (!act(ch, inv) && per < 4000) begin per++; @(negedge clk); end
  endtask

  task automatic count_low(input int ch, input logic lvl, input string req);
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== lvl) bad++;
    end
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 outputs low", 32'(pwm_out), 32'd0);
    rd(7'h40, d); chk("R10 status zero", d, 32'd0);
    rd(ra(0, 0), d); chk("R10 ctrl zero", d, 32'd0);
    rd(ra(1, 2), d); chk("R10 period zero", d, 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    cfg(1, 1, 32'h1F3);
    rd(ra(1, 1), d); chk("R1 divider readback", d, 32'hF3);
    cfg(1, 2, 32'h1234);
    rd(ra(1, 2), d); chk("R1 period readback", d, 32'h1234);
    rd(7'h20, d); chk("R1 unmapped 0x20", d, 32'd0);
    rd(7'h44, d); chk("R1 unmapped 0x44", d, 32'd0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    wr(ra(1, 3), 32'd5);
    rd(7'h40, d); chk("R2 duty flag ch1 byte", d, 32'h0000_0800);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd(7'h40, d); chk("R3 still pending", 32'(d[11]), 32'd1);
    end
    @(negedge clk); rd(7'h40, d); chk("R3 clears at fourth edge", d, 32'd0);
    wr(ra(1, 3), 32'd6);
    @(negedge clk); @(negedge clk);
    wr(ra(1, 3), 32'd7);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd(7'h40, d); chk("R3 restart keeps pending", 32'(d[11]), 32'd1);
    end
    @(negedge clk); rd(7'h40, d); chk("R3 restart clears", d, 32'd0);
    wr(ra(0, 1), 32'd2);
    rd(7'h40, d); chk("R2 divider flag ch0", d, 32'h0000_0002);
    wait_idle(0, 1);
  endtask

  task automatic t_wave();
    int hi, per;
    cfg(0, 2, 32'd4);
    cfg(0, 3, 32'd1);
    cfg(0, 0, 32'd5);
    meas(0, 1'b0, hi, per);
    chk("R4 high time div2", 32'(hi), 32'd6);
    chk("R4 frame div2", 32'(per), 32'd15);
  endtask

  task automatic t_auto();
    int hi, per;
    cfg(0, 1, 32'd0);
    cfg(0, 2, 32'd9);
    cfg(0, 3, 32'd2);
    meas(0, 1'b0, hi, per);
    chk("R5 new high at wrap", 32'(hi), 32'd3);
    chk("R5 new frame at wrap", 32'(per), 32'd10);
    sync_rise(0, 1'b0);
    wr(ra(0, 3), 32'd7);
    repeat (4) @(negedge clk);
    chk("R5 duty held after commit", 32'(pwm_out[0]), 32'd0);
    repeat (4) @(negedge clk);
    chk("R5 duty held to wrap", 32'(pwm_out[0]), 32'd0);
    meas(0, 1'b0, hi, per);
    chk("R5 duty applied after wrap", 32'(hi), 32'd8);
  endtask

  task automatic t_manual();
    int hi, per;
    logic [31:0] d;
    cfg(0, 0, 32'd1);
    sync_rise(0, 1'b0);
    wr(ra(0, 3), 32'd3);
    repeat (4) @(negedge clk);
    chk("R6 duty immediate", 32'(pwm_out[0]), 32'd0);
    meas(0, 1'b0, hi, per);
    chk("R6 duty high time", 32'(hi), 32'd4);
    cfg(0, 2, 32'd14);
    meas(0, 1'b0, hi, per);
    chk("R6 period held without load", 32'(per), 32'd10);
    wr(ra(0, 0), 32'h21);
    rd(ra(0, 0), d); chk("R6 load bits read 0", d, 32'h01);
    wait_idle(0, 0);
    meas(0, 1'b0, hi, per);
    chk("R6 period loaded", 32'(per), 32'd15);
  endtask

  task automatic t_finish();
    int hi, per;
    cfg(0, 0, 32'd5);
    cfg(0, 2, 32'd9);
    cfg(0, 3, 32'd8);
    meas(0, 1'b0, hi, per);
    chk("R7 running high", 32'(hi), 32'd9);
    sync_rise(0, 1'b0);
    wr(ra(0, 0), 32'd4);
    chk("R7 still high after disable", 32'(pwm_out[0]), 32'd1);
    repeat (7) @(negedge clk);
    chk("R7 period continues", 32'(pwm_out[0]), 32'd1);
    @(negedge clk);
    chk("R7 low at count 9", 32'(pwm_out[0]), 32'd0);
    count_low(0, 1'b0, "R7 idle after wrap");
  endtask

  task automatic t_stop();
    int hi, per;
    cfg(0, 0, 32'd5);
    meas(0, 1'b0, hi, per);
    chk("R7 restart frame", 32'(per), 32'd10);
    sync_rise(0, 1'b0);
    wr(ra(0, 0), 32'hC);
    repeat (4) @(negedge clk);
    chk("R8 high until commit", 32'(pwm_out[0]), 32'd1);
    @(negedge clk);
    chk("R8 idle one edge after commit", 32'(pwm_out[0]), 32'd0);
    count_low(0, 1'b0, "R8 stays idle");
  endtask

  task automatic t_inv();
    int hi, per;
    cfg(1, 1, 32'd1);
    cfg(1, 2, 32'd3);
    cfg(1, 3, 32'd0);
    cfg(1, 0, 32'd2);
    chk("R9 inverted idle high", 32'(pwm_out[1]), 32'd1);
    cfg(1, 0, 32'd7);
    cfg(0, 0, 32'd5);
    meas(1, 1'b1, hi, per);
    chk("R9 inverted active low time", 32'(hi), 32'd2);
    chk("R11 ch1 frame", 32'(per), 32'd8);
    meas(0, 1'b0, hi, per);
    chk("R11 ch0 high", 32'(hi), 32'd9);
    chk("R11 ch0 frame", 32'(per), 32'd10);
    cfg(1, 0, 32'hA);
    repeat (2) @(negedge clk);
    chk("R9 inverted stop idles high", 32'(pwm_out[1]), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_pend();
    t_wave();
    t_auto();
    t_manual();
    t_finish();
    t_stop();
    t_inv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule